// File: doc/BRIEF.md
# DS3 FEAC Codeword Transmitter

This block turns far-end alarm and control codes into the serial bit stream a DS3 framer places in its C-bit channel. Two 6-bit codes, A and B, are held in a 16-bit data register. A command input starts a burst that either repeats code A, or repeats code A and then code B. Each code is sent a programmed number of times (ten by default). The output is all ones whenever no codeword is going out.

The surrounding framer pulses `bit_en` once for each bit slot it reserves for this channel. The serial output changes only on those pulses. A live idle bit shows whether a codeword is on the line. A latched flag records each return to idle, and software clears it by pulsing a write-one-to-clear input. Command and code writes are taken up only between codewords, so a codeword that has started always goes out whole.

Top module: `feac_tx`

## Requirements
- R1: `code_rdata` returns code A in bits 5:0 and code B in bits 13:8 of the last value written through `code_we`. Bits 15:14 and 7:6 read as zero, and the whole register is zero after reset.
- R2: In the cycle after reset is released, `ser_out` is 1, `idle_live` is 1 and `idle_latched` is 1.
- R3: While no codeword is being sent, `ser_out` is 1 on every bit slot.
- R4: Each codeword is 16 bits, in this order: a 0, then the code bits with code bit 0 first and code bit 5 sixth, then a 0, then eight 1s.
- R5: `ser_out` and `idle_live` change only on a clock edge where `bit_en` is high.
- R6: Command value 1 sends ten copies of code A and then returns to idle.
- R7: Command value 2 sends ten copies of code A followed by ten copies of code B, and then returns to idle.
- R8: `idle_live` goes to 0 with the first bit of the first codeword of a burst. It stays 0 through the last bit of the final copy and returns to 1 on the next bit slot.
- R9: `idle_latched` sets when `idle_live` rises. It stays set until `flag_clr` is pulsed, and a rise in the same cycle as the clear leaves it set.
- R10: Code and command writes take effect only at a codeword boundary. A code written during a codeword first appears in the next copy. Command value 0 or 3 ends the burst after the current codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-slot strobe; the serial output advances only when this is high |
| code_we | input | 1 | Write strobe for the code register |
| code_wdata | input | 16 | Code register write data: A in 5:0, B in 13:8 |
| cmd_we | input | 1 | Write strobe for the command |
| cmd_mode | input | 2 | Command: 0 stop, 1 code A, 2 A then B, 3 stop |
| flag_clr | input | 1 | Write-one pulse that clears the latched idle flag |
| code_rdata | output | 16 | Code register readback |
| ser_out | output | 1 | Serial codeword / idle stream |
| idle_live | output | 1 | 1 while idle ones are sent, 0 during a codeword |
| idle_latched | output | 1 | Sticky flag for the return to idle |

## Verification
The assertions check the following on every cycle:
- the post-reset state;
- that the output and the live idle bit hold between strobes;
- that idle always means a 1 on the line;
- that a falling idle bit coincides with the leading zero of a codeword;
- that the latched flag sets on a rising idle bit and holds until a clear.

Some behaviour only the bench's scenarios can show:
- the bit order inside a codeword and the repetition counts;
- the switch from A to B;
- a code write during a codeword appearing only in the next copy;
- a stop command ending the burst after the current codeword;
- the set-wins case, where a clear arrives in the same cycle as the return to idle.

// File: rtl/feac_tx_pkg.sv
package feac_tx_pkg;

    localparam int CODE_W    = 6;
    localparam int FRAME_LEN = 16;
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam int REG_W     = 16;
    localparam int B_LSB     = 8;

    typedef enum logic [1:0] {
        CMD_STOP   = 2'd0,
        CMD_SEND_A = 2'd1,
        CMD_ALT_AB = 2'd2,
        CMD_STOP2  = 2'd3
    } cmd_e;

    typedef struct packed {
        logic [CODE_W-1:0] b;
        logic [CODE_W-1:0] a;
    } codes_t;

    typedef struct packed {
        logic valid;
        cmd_e mode;
    } pend_t;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_SHIFT = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_IDLE  = 2'd3
    } act_e;

    // Frame laid out in send order, index 0 first: 0, code[0..5], 0, then ones
    function automatic logic [FRAME_LEN-1:0] build_frame(input logic [CODE_W-1:0] code);
        logic [FRAME_LEN-1:0] f;
        f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < CODE_W; i++) begin
            f[i+1] = code[i];
        end
        f[CODE_W+1] = 1'b0;
        return f;
    endfunction

endpackage

// File: rtl/feac_tx_regs.sv
module feac_tx_regs
    import feac_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             code_we,
    input  logic [REG_W-1:0] code_wdata,
    input  logic             cmd_we,
    input  logic [1:0]       cmd_mode,
    input  logic             flag_clr,
    input  logic             take,
    input  logic             idle_rise,
    output codes_t           codes,
    output pend_t            pend,
    output logic             idle_latched
);

    wire unused_bits = ^{code_wdata[REG_W-1:B_LSB+CODE_W], code_wdata[B_LSB-1:CODE_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            codes <= '0;
        end else if (code_we) begin
            codes.a <= code_wdata[CODE_W-1:0];
            codes.b <= code_wdata[B_LSB+CODE_W-1:B_LSB];
        end
    end

    // A fresh command write overrides a take in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            pend.valid <= 1'b0;
            pend.mode  <= CMD_STOP;
        end else if (cmd_we) begin
            pend.valid <= 1'b1;
            pend.mode  <= cmd_e'(cmd_mode);
        end else if (take) begin
            pend.valid <= 1'b0;
        end
    end

    // Sticky idle flag: forced at reset, set beats clear
    always_ff @(posedge clk) begin
        if (rst) begin
            idle_latched <= 1'b1;
        end else if (idle_rise) begin
            idle_latched <= 1'b1;
        end else if (flag_clr) begin
            idle_latched <= 1'b0;
        end
    end

endmodule

// File: rtl/feac_tx_seq.sv
module feac_tx_seq
    import feac_tx_pkg::*;
#(
    parameter int REPS = 10
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   bit_en,
    input  codes_t codes,
    input  pend_t  pend,
    output logic   take,
    output logic   ser_out,
    output logic   idle_live,
    output logic   idle_rise
);

    localparam int REP_W = $clog2(REPS + 1);

    logic                 busy;
    logic                 on_b;
    logic                 alt;
    logic [CNT_W-1:0]     bit_idx;
    logic [REP_W-1:0]     rep_cnt;
    logic [FRAME_LEN-1:0] frame;

    act_e                 act;
    logic                 n_on_b;
    logic                 n_alt;
    logic [REP_W-1:0]     n_rep;
    logic                 at_edge;
    logic [FRAME_LEN-1:0] load_frame;

    assign at_edge = !busy || (bit_idx == CNT_W'(FRAME_LEN - 1));

    always_comb begin
        act    = ACT_NONE;
        take   = 1'b0;
        n_on_b = on_b;
        n_alt  = alt;
        n_rep  = rep_cnt;
        if (bit_en) begin
            if (!at_edge) begin
                act = ACT_SHIFT;
            end else if (pend.valid) begin
                take = 1'b1;
                if (pend.mode == CMD_SEND_A || pend.mode == CMD_ALT_AB) begin
                    act    = ACT_LOAD;
                    n_on_b = 1'b0;
                    n_alt  = (pend.mode == CMD_ALT_AB);
                    n_rep  = '0;
                end else begin
                    act = ACT_IDLE;
                end
            end else if (busy) begin
                if (rep_cnt != REP_W'(REPS - 1)) begin
                    act   = ACT_LOAD;
                    n_rep = rep_cnt + REP_W'(1);
                end else if (alt && !on_b) begin
                    act    = ACT_LOAD;
                    n_on_b = 1'b1;
                    n_rep  = '0;
                end else begin
                    act = ACT_IDLE;
                end
            end
        end
    end

    assign load_frame = build_frame(n_on_b ? codes.b : codes.a);
    assign idle_rise  = (act == ACT_IDLE) && busy;
    assign idle_live  = !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            on_b    <= 1'b0;
            alt     <= 1'b0;
            bit_idx <= '0;
            rep_cnt <= '0;
            frame   <= '1;
            ser_out <= 1'b1;
        end else begin
            unique case (act)
                ACT_LOAD: begin
                    frame   <= load_frame;
                    ser_out <= load_frame[0];
                    bit_idx <= '0;
                    busy    <= 1'b1;
                    on_b    <= n_on_b;
                    alt     <= n_alt;
                    rep_cnt <= n_rep;
                end
                ACT_SHIFT: begin
                    bit_idx <= bit_idx + CNT_W'(1);
                    ser_out <= frame[bit_idx + CNT_W'(1)];
                end
                ACT_IDLE: begin
                    busy    <= 1'b0;
                    bit_idx <= '0;
                    ser_out <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/feac_tx.sv
module feac_tx
    import feac_tx_pkg::*;
#(
    parameter int REPS = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bit_en,
    input  logic        code_we,
    input  logic [15:0] code_wdata,
    input  logic        cmd_we,
    input  logic [1:0]  cmd_mode,
    input  logic        flag_clr,
    output logic [15:0] code_rdata,
    output logic        ser_out,
    output logic        idle_live,
    output logic        idle_latched
);

    codes_t codes;
    pend_t  pend;
    logic   take;
    logic   idle_rise;

    feac_tx_regs regs_i (
        .clk          (clk),
        .rst          (rst),
        .code_we      (code_we),
        .code_wdata   (code_wdata),
        .cmd_we       (cmd_we),
        .cmd_mode     (cmd_mode),
        .flag_clr     (flag_clr),
        .take         (take),
        .idle_rise    (idle_rise),
        .codes        (codes),
        .pend         (pend),
        .idle_latched (idle_latched)
    );

    feac_tx_seq #(.REPS(REPS)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .codes     (codes),
        .pend      (pend),
        .take      (take),
        .ser_out   (ser_out),
        .idle_live (idle_live),
        .idle_rise (idle_rise)
    );

    always_comb begin
        code_rdata = '0;
        code_rdata[CODE_W-1:0]             = codes.a;
        code_rdata[B_LSB+CODE_W-1:B_LSB]   = codes.b;
    end

endmodule

// File: rtl/feac_tx_chk.sv
module feac_tx_chk (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic flag_clr,
    input logic ser_out,
    input logic idle_live,
    input logic idle_latched
);

    a_r2_reset_state: assert property (@(posedge clk)
        rst |=> (ser_out && idle_live && idle_latched));

    a_r5_hold_out: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(ser_out));

    a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(idle_live));

    a_r3_idle_ones: assert property (@(posedge clk) disable iff (rst)
        idle_live |-> ser_out);

    a_r8_start_zero: assert property (@(posedge clk) disable iff (rst)
        $fell(idle_live) |-> !ser_out);

    a_r9_latch_set: assert property (@(posedge clk) disable iff (rst)
        $rose(idle_live) |-> idle_latched);

    a_r9_latch_hold: assert property (@(posedge clk) disable iff (rst)
        (idle_latched && !flag_clr) |=> idle_latched);

endmodule

bind feac_tx feac_tx_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .bit_en       (bit_en),
    .flag_clr     (flag_clr),
    .ser_out      (ser_out),
    .idle_live    (idle_live),
    .idle_latched (idle_latched)
);

// File: tb/feac_tx_tb_top.sv
`timescale 1ns/1ps
module feac_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_en = 1'b0;
    logic        code_we = 1'b0;
    logic [15:0] code_wdata = '0;
    logic        cmd_we = 1'b0;
    logic [1:0]  cmd_mode = '0;
    logic        flag_clr = 1'b0;
    logic [15:0] code_rdata;
    logic        ser_out;
    logic        idle_live;
    logic        idle_latched;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    feac_tx dut_i (
        .clk          (clk),
        .rst          (rst),
        .bit_en       (bit_en),
        .code_we      (code_we),
        .code_wdata   (code_wdata),
        .cmd_we       (cmd_we),
        .cmd_mode     (cmd_mode),
        .flag_clr     (flag_clr),
        .code_rdata   (code_rdata),
        .ser_out      (ser_out),
        .idle_live    (idle_live),
        .idle_latched (idle_latched)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [5:0] code, input int k);
        if (k == 0 || k == 7) return 1'b0;
        if (k >= 1 && k <= 6) return code[k-1];
        return 1'b1;
    endfunction

    function automatic logic [15:0] exp_rd(input logic [15:0] d);
        return {2'b00, d[13:8], 2'b00, d[5:0]};
    endfunction

    task automatic write_codes(input logic [15:0] d);
        code_we = 1'b1; code_wdata = d;
        @(negedge clk);
        code_we = 1'b0;
    endtask

    task automatic write_cmd(input logic [1:0] m);
        cmd_we = 1'b1; cmd_mode = m;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    // Random gap without strobe (output must hold), then one strobe
    task automatic tick(input logic clr);
        logic prev;
        int gap;
        prev = ser_out;
        gap = $urandom_range(0, 2);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            chk("R5 hold without bit_en", ser_out, prev);
        end
        bit_en = 1'b1; flag_clr = clr;
        @(negedge clk);
        bit_en = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic expect_word(input logic [5:0] code, input string req,
                               input logic do_wr, input logic [15:0] wr_d);
        for (int k = 0; k < 16; k++) begin
            if (do_wr && k == 5) write_codes(wr_d);
            tick(1'b0);
            chk({req, " R4 bit"}, ser_out, exp_bit(code, k));
            chk("R8 idle_live low in word", idle_live, 1'b0);
        end
    endtask

    task automatic expect_idle_tail(input int n);
        for (int i = 0; i < n; i++) begin
            tick(1'b0);
            chk("R3 idle ones", ser_out, 1'b1);
            chk("R8 idle_live high", idle_live, 1'b1);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [5:0]  ca, cb, ca2;
        void'($urandom(32'h5EED_F0AC));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        chk("R1 reset readback", code_rdata, 16'h0000);
        chk("R2 reset ser_out", ser_out, 1'b1);
        chk("R2 reset idle_live", idle_live, 1'b1);
        chk("R2 reset idle_latched", idle_latched, 1'b1);

        write_codes(16'hFFFF);
        chk("R1 reserved bits zero", code_rdata, 16'h3F3F);
        for (int i = 0; i < 8; i++) begin
            d = 16'($urandom);
            write_codes(d);
            chk("R1 readback", code_rdata, exp_rd(d));
        end

        pulse_clr();
        chk("R9 clear without rise", idle_latched, 1'b0);

        expect_idle_tail(12);
        chk("R9 stays clear while idle", idle_latched, 1'b0);

        // Command pending but no strobe: line must stay idle
        write_codes(16'h0015);
        write_cmd(2'd1);
        repeat (4) begin
            @(negedge clk);
            chk("R5 no strobe no start", ser_out, 1'b1);
            chk("R5 idle_live holds", idle_live, 1'b1);
        end

        // R6 with a code change in copy 3 (R10)
        ca = 6'h15; ca2 = 6'h2A;
        for (int c = 0; c < 10; c++) begin
            if (c == 3) expect_word(ca, "R6/R10 copy", 1'b1, {8'h00, 2'b00, ca2});
            else if (c < 3) expect_word(ca, "R6 copy", 1'b0, 16'h0);
            else expect_word(ca2, "R10 new code next copy", 1'b0, 16'h0);
        end
        expect_idle_tail(1);
        chk("R6 back to idle latched", idle_latched, 1'b1);
        expect_idle_tail(5);

        // R7 alternate, twice; second time clear coincides with return to idle
        for (int it = 0; it < 2; it++) begin
            ca = 6'($urandom); cb = 6'($urandom);
            write_codes({2'b00, cb, 2'b00, ca});
            pulse_clr();
            chk("R9 cleared before burst", idle_latched, 1'b0);
            write_cmd(2'd2);
            for (int c = 0; c < 10; c++) expect_word(ca, "R7 A copy", 1'b0, 16'h0);
            for (int c = 0; c < 10; c++) expect_word(cb, "R7 B copy", 1'b0, 16'h0);
            tick(it == 1);
            chk("R7 idle after B", ser_out, 1'b1);
            chk("R8 idle_live rises", idle_live, 1'b1);
            chk(it == 1 ? "R9 set wins over clear" : "R9 set on rise", idle_latched, 1'b1);
            expect_idle_tail(3);
        end

        // R10 stop command mid-word ends after the current codeword
        ca = 6'h33;
        write_codes({8'h00, 2'b00, ca});
        write_cmd(2'd1);
        expect_word(ca, "R10 pre-stop", 1'b0, 16'h0);
        for (int k = 0; k < 16; k++) begin
            if (k == 4) write_cmd(2'd0);
            tick(1'b0);
            chk("R10 current word completes", ser_out, exp_bit(ca, k));
        end
        expect_idle_tail(20);

        // Mode 3 also stops
        write_cmd(2'd1);
        expect_word(ca, "R10 before mode3", 1'b0, 16'h0);
        write_cmd(2'd3);
        expect_idle_tail(17);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule